// File: doc/BRIEF.md
# Fractional Audio DSP Execution Unit

This block is the arithmetic stage of a 32-bit fixed-point audio signal processor. Each cycle it may accept one operation, made of a 4-bit opcode and three signed operands A, X and Y. One clock later it returns a 32-bit result with a flag that tells whether the result was clamped. Operand fetch, the register file and instruction sequencing sit outside the block.

The operations cover several kinds of arithmetic. There are Q31 fractional multiply-add forms, which saturate or wrap and may negate the product. There are integer multiply-add forms, a saturating three-way add, a bitwise mask-and-toggle, and compare-and-select forms. A saturating linear interpolation is also included. One opcode leaves the result equal to A and adds the fractional product into a wide internal accumulator, which is visible on `acc_o`. The three opcodes that a neighbouring unit or the sequencer handles (12, 13 and 15) return A unchanged.

Top module: `fx_exec_unit`

## Requirements
- R1: A result is due one clock after the edge at which `valid_i` is sampled high. `valid_o` is high for exactly that cycle. While no operation is issued, `valid_o` and `sat_o` stay low and `r_o` keeps its last value.
- R2: Driving `rst_ni` low clears `r_o`, `valid_o`, `sat_o` and the accumulator `acc_o` to zero at once, without waiting for a clock edge.
- R3: Opcode 0 gives A + ((X*Y) >>> 31), where the product is signed and the shift is arithmetic, so it rounds toward minus infinity. Opcode 1 gives A + ((-(X*Y)) >>> 31). Both saturate.
- R4: Opcodes 2 and 3 compute the same sums as opcodes 0 and 1, keep only the low 32 bits, and never set `sat_o`.
- R5: Opcode 4 gives A + X*Y, saturating, with the full integer product. Opcode 5 forms the same sum, keeps bits 30:0, and copies bit 30 into bit 31. It never sets `sat_o`.
- R6: Opcode 6 gives A + X + Y, saturating.
- R7: Opcode 7 returns A. It also adds (X*Y) >>> 31, sign-extended, into the 48-bit accumulator, which wraps on overflow. No other opcode changes the accumulator.
- R8: Opcode 8 gives (A & X) ^ Y. Opcode 9 gives X when A >= Y (signed), otherwise ~X.
- R9: Opcode 10 gives X when A >= Y, otherwise Y. Opcode 11 gives X when A < Y, otherwise Y. Both compares are signed.
- R10: Opcode 14 gives A + ((X*(Y-A)) >>> 31), saturating, where Y-A is formed exactly in 33 bits.
- R11: Opcodes 12, 13 and 15 return A unchanged with `sat_o` low.
- R12: A saturating opcode clamps a sum above 0x7FFFFFFF to 0x7FFFFFFF and a sum below 0x80000000 to 0x80000000. `sat_o` is high exactly when such a clamp happened.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Issue strobe for the operation on op_i, a_i, x_i, y_i |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | Operand A, signed |
| x_i | input | 32 | Operand X, signed |
| y_i | input | 32 | Operand Y, signed |
| valid_o | output | 1 | Result valid, one cycle after issue |
| r_o | output | 32 | Registered result |
| sat_o | output | 1 | Result was clamped |
| acc_o | output | 48 | Internal multiply accumulator |

## Verification
Every operation settles in one register stage. The result, the clamp flag, the valid strobe and the accumulator update are all due in the cycle that follows the issuing edge. The bench drives each operation on a falling edge and holds `valid_i` for one rising edge. It compares all four outputs at the next falling edge, which is the first sample point after the single register stage. On the falling edge after that, with `valid_i` low, it checks that the result holds and that the valid and clamp flags have dropped. The reset check is made while `rst_ni` is still low, before any clock edge, so it shows that the clear does not wait for the clock.

// File: rtl/fx_exec_pkg.sv
package fx_exec_pkg;
  typedef enum logic [3:0] {
    OP_QMAC_S   = 4'h0,
    OP_QMACN_S  = 4'h1,
    OP_QMAC_W   = 4'h2,
    OP_QMACN_W  = 4'h3,
    OP_IMAC_S   = 4'h4,
    OP_IMAC_W31 = 4'h5,
    OP_ADD3_S   = 4'h6,
    OP_ACC_ONLY = 4'h7,
    OP_MASK_TGL = 4'h8,
    OP_CMP_INV  = 4'h9,
    OP_SEL_GE   = 4'ha,
    OP_SEL_LT   = 4'hb,
    OP_EXT_C    = 4'hc,
    OP_EXT_D    = 4'hd,
    OP_LERP_S   = 4'he,
    OP_SEQ_F    = 4'hf
  } fx_op_e;
endpackage

// File: rtl/fx_mul.sv
module fx_mul #(
  parameter int AW = 32,
  parameter int BW = 32
) (
  input  logic signed [AW-1:0]    a_i,
  input  logic signed [BW-1:0]    b_i,
  output logic signed [AW+BW-1:0] p_o
);
  assign p_o = a_i * b_i;
endmodule

// File: rtl/fx_sat.sv
module fx_sat #(
  parameter int IW = 67,
  parameter int OW = 32
) (
  input  logic signed [IW-1:0] v_i,
  output logic [OW-1:0]        q_o,
  output logic                 ovf_o
);
  localparam logic signed [IW-1:0] MAXV = {{(IW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [IW-1:0] MINV = {{(IW-OW+1){1'b1}}, {(OW-1){1'b0}}};

  always_comb begin
    if (v_i > MAXV) begin
      q_o   = {1'b0, {(OW-1){1'b1}}};
      ovf_o = 1'b1;
    end else if (v_i < MINV) begin
      q_o   = {1'b1, {(OW-1){1'b0}}};
      ovf_o = 1'b1;
    end else begin
      q_o   = v_i[OW-1:0];
      ovf_o = 1'b0;
    end
  end
endmodule

// File: rtl/fx_exec_unit.sv
module fx_exec_unit
  import fx_exec_pkg::*;
#(
  parameter int DW    = 32,
  parameter int ACC_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [3:0]       op_i,
  input  logic [DW-1:0]    a_i,
  input  logic [DW-1:0]    x_i,
  input  logic [DW-1:0]    y_i,
  output logic             valid_o,
  output logic [DW-1:0]    r_o,
  output logic             sat_o,
  output logic [ACC_W-1:0] acc_o
);
  localparam int FRAC = DW - 1;
  localparam int PW   = 2 * DW;
  localparam int SW   = PW + 3;

  logic signed [PW-1:0] prod_xy;
  logic signed [PW:0]   prod_lerp;
  logic signed [DW:0]   diff_ya;
  logic signed [SW-1:0] a_e, x_e, y_e, pxy_e, plerp_e;
  logic signed [SW-1:0] q_pos, q_neg, q_lerp;
  logic signed [SW-1:0] s_pos, s_neg, s_int, s_add, s_lerp;
  logic signed [SW-1:0] sat_v;
  logic [DW-1:0]        sat_q, r_d;
  logic                 sat_ovf, sat_d, use_sat, acc_en;
  logic                 a_ge_y;
  fx_op_e               op;

  assign op      = fx_op_e'(op_i);
  assign diff_ya = $signed({y_i[DW-1], y_i}) - $signed({a_i[DW-1], a_i});
  assign a_ge_y  = $signed(a_i) >= $signed(y_i);

  fx_mul #(.AW(DW), .BW(DW)) u_mul_xy (
    .a_i(x_i), .b_i(y_i), .p_o(prod_xy)
  );

  fx_mul #(.AW(DW), .BW(DW+1)) u_mul_lerp (
    .a_i(x_i), .b_i(diff_ya), .p_o(prod_lerp)
  );

  assign a_e     = {{(SW-DW){a_i[DW-1]}}, a_i};
  assign x_e     = {{(SW-DW){x_i[DW-1]}}, x_i};
  assign y_e     = {{(SW-DW){y_i[DW-1]}}, y_i};
  assign pxy_e   = {{(SW-PW){prod_xy[PW-1]}}, prod_xy};
  assign plerp_e = {{(SW-PW-1){prod_lerp[PW]}}, prod_lerp};

  // Q31 scaling: arithmetic shift, floor rounding
  assign q_pos  = pxy_e >>> FRAC;
  assign q_neg  = (-pxy_e) >>> FRAC;
  assign q_lerp = plerp_e >>> FRAC;

  assign s_pos  = a_e + q_pos;
  assign s_neg  = a_e + q_neg;
  assign s_int  = a_e + pxy_e;
  assign s_add  = a_e + x_e + y_e;
  assign s_lerp = a_e + q_lerp;

  always_comb begin
    sat_v   = s_pos;
    use_sat = 1'b0;
    acc_en  = 1'b0;
    r_d     = a_i;
    unique case (op)
      OP_QMAC_S:   begin sat_v = s_pos;  use_sat = 1'b1; end
      OP_QMACN_S:  begin sat_v = s_neg;  use_sat = 1'b1; end
      OP_QMAC_W:   r_d = s_pos[DW-1:0];
      OP_QMACN_W:  r_d = s_neg[DW-1:0];
      OP_IMAC_S:   begin sat_v = s_int;  use_sat = 1'b1; end
      OP_IMAC_W31: r_d = {s_int[FRAC-1], s_int[FRAC-1:0]};
      OP_ADD3_S:   begin sat_v = s_add;  use_sat = 1'b1; end
      OP_ACC_ONLY: acc_en = 1'b1;
      OP_MASK_TGL: r_d = (a_i & x_i) ^ y_i;
      OP_CMP_INV:  r_d = a_ge_y ? x_i : ~x_i;
      OP_SEL_GE:   r_d = a_ge_y ? x_i : y_i;
      OP_SEL_LT:   r_d = a_ge_y ? y_i : x_i;
      OP_LERP_S:   begin sat_v = s_lerp; use_sat = 1'b1; end
      default:     r_d = a_i;
    endcase
    if (use_sat) r_d = sat_q;
    sat_d = use_sat & sat_ovf;
  end

  fx_sat #(.IW(SW), .OW(DW)) u_sat (
    .v_i(sat_v), .q_o(sat_q), .ovf_o(sat_ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sat_o   <= 1'b0;
      r_o     <= '0;
      acc_o   <= '0;
    end else begin
      valid_o <= valid_i;
      sat_o   <= valid_i & sat_d;
      if (valid_i) r_o <= r_d;
      if (valid_i && acc_en) acc_o <= acc_o + q_pos[ACC_W-1:0];
    end
  end
endmodule

// File: rtl/fx_exec_unit_chk.sv
module fx_exec_unit_chk #(
  parameter int DW    = 32,
  parameter int ACC_W = 48
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [3:0]       op_i,
  input logic [DW-1:0]    a_i,
  input logic             valid_o,
  input logic [DW-1:0]    r_o,
  input logic             sat_o,
  input logic [ACC_W-1:0] acc_o
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);  // R1
  AST_VALID_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !sat_o));  // R1
  AST_RESULT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(r_o));  // R1
  AST_SAT_CLAMP_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_o |-> (r_o == {1'b0, {(DW-1){1'b1}}} || r_o == {1'b1, {(DW-1){1'b0}}}));  // R12
  AST_ACC_UNTOUCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && op_i == 4'h7) |=> $stable(acc_o));  // R7
  AST_ACC_OP_PASSES_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'h7) |=> (r_o == $past(a_i) && !sat_o));  // R7
  AST_EXT_PASSES_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 4'hc || op_i == 4'hd || op_i == 4'hf)) |=> (r_o == $past(a_i) && !sat_o));  // R11
  AST_WRAP_NO_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 4'h2 || op_i == 4'h3 || op_i == 4'h5)) |=> !sat_o);  // R4 R5
endmodule

bind fx_exec_unit fx_exec_unit_chk #(.DW(DW), .ACC_W(ACC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i), .a_i(a_i),
  .valid_o(valid_o), .r_o(r_o), .sat_o(sat_o), .acc_o(acc_o)
);

// File: tb/fx_exec_unit_test.sv
module fx_exec_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] a_i = '0, x_i = '0, y_i = '0;
  logic        valid_o, sat_o;
  logic [31:0] r_o;
  logic [47:0] acc_o;
  logic [47:0] acc_exp = '0;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fx_exec_unit uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .a_i(a_i), .x_i(x_i), .y_i(y_i), .valid_o(valid_o), .r_o(r_o),
    .sat_o(sat_o), .acc_o(acc_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [32:0] clampv(input logic signed [95:0] s);
    if (s > 96'sh7fffffff) return {1'b1, 32'h7fffffff};
    if (s < -96'sh80000000) return {1'b1, 32'h80000000};
    return {1'b0, s[31:0]};
  endfunction

  // returns {sat, result}
  function automatic logic [32:0] model(input logic [3:0] op, input logic [31:0] a, x, y);
    logic signed [95:0] ae, xe, ye, p;
    ae = {{64{a[31]}}, a};
    xe = {{64{x[31]}}, x};
    ye = {{64{y[31]}}, y};
    p  = xe * ye;
    case (op)
      4'h0: return clampv(ae + (p >>> 31));
      4'h1: return clampv(ae + ((-p) >>> 31));
      4'h2: return {1'b0, 32'(ae + (p >>> 31))};
      4'h3: return {1'b0, 32'(ae + ((-p) >>> 31))};
      4'h4: return clampv(ae + p);
      4'h5: begin
        logic signed [95:0] s;
        s = ae + p;
        return {1'b0, s[30], s[30:0]};
      end
      4'h6: return clampv(ae + xe + ye);
      4'h8: return {1'b0, (a & x) ^ y};
      4'h9: return {1'b0, (ae >= ye) ? x : ~x};
      4'ha: return {1'b0, (ae >= ye) ? x : y};
      4'hb: return {1'b0, (ae < ye) ? x : y};
      4'he: return clampv(ae + ((xe * (ye - ae)) >>> 31));
      default: return {1'b0, a};
    endcase
  endfunction

  function automatic string tag(input logic [3:0] op);
    case (op)
      4'h0, 4'h1: return "R3";
      4'h2, 4'h3: return "R4";
      4'h4, 4'h5: return "R5";
      4'h6: return "R6";
      4'h7: return "R7";
      4'h8, 4'h9: return "R8";
      4'ha, 4'hb: return "R9";
      4'he: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic run_op(input logic [3:0] op, input logic [31:0] a, x, y);
    logic [32:0] e;
    logic [31:0] r_prev;
    logic signed [95:0] p;
    e = model(op, a, x, y);
    @(negedge clk_i);
    op_i = op; a_i = a; x_i = x; y_i = y; valid_i = 1'b1;
    if (op == 4'h7) begin
      p = ({{64{x[31]}}, x} * {{64{y[31]}}, y}) >>> 31;
      acc_exp = acc_exp + p[47:0];
    end
    @(negedge clk_i);
    valid_i = 1'b0;
    chk(r_o == e[31:0], tag(op), 64'(r_o), 64'(e[31:0]));
    chk(sat_o == e[32], "R12 sat", 64'(sat_o), 64'(e[32]));
    chk(valid_o == 1'b1, "R1 valid", 64'(valid_o), 64'd1);
    chk(acc_o == acc_exp, "R7 acc", 64'(acc_o), 64'(acc_exp));
    r_prev = r_o;
    @(negedge clk_i);
    chk(valid_o == 1'b0 && sat_o == 1'b0 && r_o == r_prev, "R1 idle",
        {31'd0, valid_o, sat_o, r_o}, {33'd0, r_prev});
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 8)
      0: return 32'h7fffffff;
      1: return 32'h80000000;
      2: return 32'h0;
      3: return 32'hffffffff;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #1;
    chk(r_o == 0 && valid_o == 0 && sat_o == 0 && acc_o == 0, "R2 reset",
        {14'd0, acc_o[15:0], valid_o, sat_o, r_o}, 64'd0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R3 corners
    run_op(4'h0, 32'h0, 32'h80000000, 32'h80000000);   // clamps high
    chk(r_o == 32'h7fffffff, "R12 high clamp", 64'(r_o), 64'h7fffffff);
    run_op(4'h1, 32'h0, 32'h1, 32'h1);                 // floor gives -1
    chk(r_o == 32'hffffffff, "R3 floor", 64'(r_o), 64'hffffffff);
    run_op(4'h1, 32'h80000000, 32'h40000000, 32'h40000000);
    chk(r_o == 32'h80000000, "R12 low clamp", 64'(r_o), 64'h80000000);
    // R4 wrap of the same high case
    run_op(4'h2, 32'h0, 32'h80000000, 32'h80000000);
    chk(r_o == 32'h80000000, "R4 wrap", 64'(r_o), 64'h80000000);
    run_op(4'h3, 32'h7fffffff, 32'h80000000, 32'h7fffffff);
    // R5
    run_op(4'h5, 32'h0, 32'h20000000, 32'h2);
    chk(r_o == 32'hc0000000, "R5 bit30 extend", 64'(r_o), 64'hc0000000);
    run_op(4'h4, 32'h7ffffff0, 32'h10, 32'h10);
    // R6
    run_op(4'h6, 32'h7fffffff, 32'h1, 32'h0);
    run_op(4'h6, 32'h80000000, 32'hffffffff, 32'h1);
    // R7 accumulate
    run_op(4'h7, 32'h1234, 32'h40000000, 32'h40000000);
    run_op(4'h7, 32'h5678, 32'h80000000, 32'h7fffffff);
    // R8 R9 compare edges
    run_op(4'h9, 32'h5, 32'haaaa5555, 32'h5);
    run_op(4'h9, 32'h80000000, 32'haaaa5555, 32'h0);
    run_op(4'ha, 32'hffffffff, 32'h11, 32'h1);
    run_op(4'hb, 32'hffffffff, 32'h11, 32'h1);
    run_op(4'h8, 32'hf0f0f0f0, 32'hff00ff00, 32'h0f0f0f0f);
    // R10
    run_op(4'he, 32'h10, 32'h40000000, 32'h20);
    chk(r_o == 32'h18, "R10 midpoint", 64'(r_o), 64'h18);
    run_op(4'he, 32'h80000000, 32'h80000000, 32'h7fffffff);
    // R11
    run_op(4'hc, 32'hdeadbeef, 32'h1, 32'h2);
    run_op(4'hf, 32'h80000000, 32'h7fffffff, 32'h7fffffff);

    for (int i = 0; i < 600; i++) begin
      logic [31:0] ra, rx, ry;
      ra = pick(); rx = pick(); ry = pick();
      run_op(4'($urandom), ra, rx, ry);
    end

    // R2 mid-run reset clears accumulator without a clock edge
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(acc_o == 0 && r_o == 0 && valid_o == 0, "R2 async clear",
        {15'd0, acc_o[15:0], valid_o, r_o}, 64'd0);
    acc_exp = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    run_op(4'h7, 32'h0, 32'h7fffffff, 32'h7fffffff);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule